// File: doc/BRIEF.md
# External Line Interrupt and Wakeup Controller

This controller watches sixteen external input lines and one non-maskable line. Each line has a 4-bit configuration field that selects what counts as activity on that line (a rising edge, a falling edge, either edge, a high level or a low level) and whether a majority-of-three filter is applied first. When activity is detected, the controller sets a per-line pending flag. It then raises a maskable interrupt request, a low-power wakeup request and a per-line event pulse, each subject to its own per-line enable.

Detection advances on a detector clock, modelled as an enable strobe `det_tick` inside the bus clock domain. When the strobe stops, a line set to level sensing with its filter off still reaches the interrupt and wakeup outputs through a purely combinational path. This lets a sleeping system wake up with no detector clock running. Writes to the reset and enable controls only take effect after two detector ticks, and a busy bit shows that the write is still in progress.

Software reaches the controller through a single-cycle register bus. Writes are strobed, and reads are combinational from the address.

Top module: `eic_wake_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_o`, `wake_o` and `nmi_o` are low, and the busy bit (STAT 0x04 bit 0) is 0.
- R2: Line i is configured in register 0x20 + 4*(i/8), bits (i mod 8)*4 +: 4. Field bits [2:0] select the sense: 0 none, 1 rising, 2 falling, 3 both edges, 4 high level, 5 low level. Bit 3 enables the filter. Written values read back unchanged.
- R3: Writing 1s to IRQSET (0x10) enables those lines and writing 1s to IRQCLR (0x14) disables them. Zero bits leave the mask unchanged, and both addresses read the mask.
- R4: An enabled edge-sensed line sets its flag only on the selected transition, after passing through a two-stage synchronizer advanced by `det_tick`. Sense 0 never sets a flag.
- R5: With the filter on, the detector compares a majority vote of the last three samples. A high pulse caught by a single sample sets no flag.
- R6: FLAG (0x1C) reads the pending lines, and writing 1 clears a flag. `irq_o` is high exactly when some pending line has its interrupt enable set.
- R7: `wake_o` is high when a pending line has its bit set in WAKEEN (0x18), whatever the interrupt mask holds.
- R8: A level-sensed, unfiltered line on an enabled controller shows as pending and drives `irq_o`/`wake_o` straight from the pin with `det_tick` held low.
- R9: A filtered level line only flags on ticks. While the level is still present, its flag sets again after being cleared.
- R10: Each detection on a line with its EVTEN (0x0C) bit set gives one single-cycle pulse on `evt_o`. Lines without that bit give no pulse.
- R11: The non-maskable line uses NMICFG (0x08, 4 bits, same field coding) and NMIFLAG (0x28 bit 0, write 1 to clear). It drives `nmi_o` regardless of IRQSET/IRQCLR.
- R12: A write to CTRL (0x00: bit 0 soft reset, bit 1 enable) sets busy. It takes effect after two `det_tick` cycles, and further CTRL writes are ignored while busy.
- R13: A completed soft reset returns every register to 0, leaves the controller disabled and self-clears the reset bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_tick | input | 1 | Detector clock enable; low means the detector clock is stopped |
| pins_i | input | 16 | External interrupt lines |
| nmi_pin_i | input | 1 | Non-maskable external line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| wake_o | output | 1 | Wakeup request |
| evt_o | output | 16 | Per-line detection event pulses |

## Verification
The assertions watch the following on every cycle:
- the control timing: the effective enable moves only at the end of a busy window, and busy falls only on a tick;
- that the filter history freezes without ticks;
- the write-one-to-clear and write-one-to-set updates;
- that a soft reset empties the configuration;
- that a combinational level match always reaches the wakeup output.

Only the bench scenarios can show that each sense mode picks out the correct transition, that a one-sample glitch is rejected, that a filtered level re-flags after clearing, and how many event pulses each activity produces. The same applies to reaching the outputs with the detector clock stopped.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [2:0] {
        SNS_NONE = 3'd0,
        SNS_RISE = 3'd1,
        SNS_FALL = 3'd2,
        SNS_BOTH = 3'd3,
        SNS_HIGH = 3'd4,
        SNS_LOW  = 3'd5
    } sense_e;

    // bit 3 = filter enable, bits 2:0 = sense code
    typedef struct packed {
        logic       filt;
        logic [2:0] sense;
    } line_cfg_t;

    localparam int A_CTRL    = 'h00;
    localparam int A_STAT    = 'h04;
    localparam int A_NMICFG  = 'h08;
    localparam int A_EVTEN   = 'h0C;
    localparam int A_IRQSET  = 'h10;
    localparam int A_IRQCLR  = 'h14;
    localparam int A_WAKEEN  = 'h18;
    localparam int A_FLAG    = 'h1C;
    localparam int A_CFG0    = 'h20;
    localparam int A_NMIFLAG = 'h28;

endpackage

// File: rtl/eic_line_det.sv
module eic_line_det
    import eic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      tick,
    input  logic      en,
    input  logic      pin,
    input  line_cfg_t cfg,
    output logic      hit,
    output logic      lvl_now
);

    typedef struct packed {
        logic [1:0] sync;
        logic [2:0] hist;
        logic       prev;
    } det_t;

    det_t det_d, det_q;
    logic maj, cur;

    always_comb begin
        maj = (det_q.hist[0] & det_q.hist[1]) |
              (det_q.hist[0] & det_q.hist[2]) |
              (det_q.hist[1] & det_q.hist[2]);
        cur = cfg.filt ? maj : det_q.sync[1];

        det_d = det_q;
        if (clr) begin
            det_d = '0;
        end else if (tick) begin
            det_d.sync = {det_q.sync[0], pin};
            det_d.hist = {det_q.hist[1:0], det_q.sync[1]};
            det_d.prev = cur;
        end

        hit = 1'b0;
        if (tick && en && !clr) begin
            if (cfg.sense == SNS_RISE)      hit = cur & ~det_q.prev;
            else if (cfg.sense == SNS_FALL) hit = ~cur & det_q.prev;
            else if (cfg.sense == SNS_BOTH) hit = cur ^ det_q.prev;
            else if (cfg.sense == SNS_HIGH) hit = cur;
            else if (cfg.sense == SNS_LOW)  hit = ~cur;
            else                            hit = 1'b0;
        end

        // clockless path for unfiltered level sensing
        lvl_now = en && !cfg.filt &&
                  (((cfg.sense == SNS_HIGH) && pin) ||
                   ((cfg.sense == SNS_LOW) && !pin));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    // R5
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(det_q.hist));

endmodule

// File: rtl/eic_ctrl_sync.sv
module eic_ctrl_sync #(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic start_rst,
    input  logic start_en,
    output logic busy,
    output logic rst_pend,
    output logic en_req,
    output logic en_eff,
    output logic do_reset
);

    localparam int CW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          rst_pend;
        logic          en_req;
        logic          en_eff;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        do_reset = 1'b0;
        if (!s_q.busy && start) begin
            s_d.busy     = 1'b1;
            s_d.cnt      = '0;
            s_d.rst_pend = start_rst;
            s_d.en_req   = start_en;
        end else if (s_q.busy && tick) begin
            if (s_q.cnt == CW'(SYNC_TICKS - 1)) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                if (s_q.rst_pend) begin
                    do_reset = 1'b1;
                    s_d      = '0;
                end else begin
                    s_d.en_eff = s_q.en_req;
                end
            end else begin
                s_d.cnt = CW'(s_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign rst_pend = s_q.rst_pend;
    assign en_req   = s_q.en_req;
    assign en_eff   = s_q.en_eff;

    // R12
    en_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.en_eff) |-> $past(s_q.busy));

    // R12
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> $past(tick));

endmodule

// File: rtl/eic_wake_ctrl.sv
module eic_wake_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int SYNC_TICKS = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 det_tick,
    input  logic [NUM_LINES-1:0] pins_i,
    input  logic                 nmi_pin_i,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o,
    output logic                 nmi_o,
    output logic                 wake_o,
    output logic [NUM_LINES-1:0] evt_o
);

    localparam int LINES_PER_REG = DATA_W / FIELD_W;
    localparam int CFG_REGS      = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG;
    localparam int CFG_BITS      = CFG_REGS * DATA_W;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] wake_en;
        logic [NUM_LINES-1:0] evt_en;
        logic [NUM_LINES-1:0] flag;
        logic [CFG_BITS-1:0]  cfg;
        logic [FIELD_W-1:0]   nmi_cfg;
        logic                 nmi_flag;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_LINES-1:0] hit_vec, lvl_vec, pend;
    logic nmi_hit, nmi_lvl, nmi_pend;
    logic busy, rst_pend, en_req, en_eff, do_reset;
    logic wr_ctrl;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));

    eic_ctrl_sync #(.SYNC_TICKS(SYNC_TICKS)) ctrl_sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (det_tick),
        .start     (wr_ctrl),
        .start_rst (bus_wdata[0]),
        .start_en  (bus_wdata[1]),
        .busy      (busy),
        .rst_pend  (rst_pend),
        .en_req    (en_req),
        .en_eff    (en_eff),
        .do_reset  (do_reset)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        eic_line_det det_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (do_reset),
            .tick    (det_tick),
            .en      (en_eff),
            .pin     (pins_i[i]),
            .cfg     (line_cfg_t'(r_q.cfg[i*FIELD_W +: FIELD_W])),
            .hit     (hit_vec[i]),
            .lvl_now (lvl_vec[i])
        );
    end

    eic_line_det nmi_det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (do_reset),
        .tick    (det_tick),
        .en      (en_eff),
        .pin     (nmi_pin_i),
        .cfg     (line_cfg_t'(r_q.nmi_cfg)),
        .hit     (nmi_hit),
        .lvl_now (nmi_lvl)
    );

    always_comb begin
        r_d = r_q;
        if (do_reset) begin
            r_d = '0;
        end else begin
            if (bus_wr) begin
                if (bus_addr == ADDR_W'(A_IRQSET)) r_d.mask    = r_q.mask | bus_wdata[NUM_LINES-1:0];
                if (bus_addr == ADDR_W'(A_IRQCLR)) r_d.mask    = r_q.mask & ~bus_wdata[NUM_LINES-1:0];
                if (bus_addr == ADDR_W'(A_WAKEEN)) r_d.wake_en = bus_wdata[NUM_LINES-1:0];
                if (bus_addr == ADDR_W'(A_EVTEN))  r_d.evt_en  = bus_wdata[NUM_LINES-1:0];
                if (bus_addr == ADDR_W'(A_NMICFG)) r_d.nmi_cfg = bus_wdata[FIELD_W-1:0];
                for (int k = 0; k < CFG_REGS; k++) begin
                    if (bus_addr == ADDR_W'(A_CFG0 + 4 * k))
                        r_d.cfg[k*DATA_W +: DATA_W] = bus_wdata;
                end
            end
            r_d.flag = (r_q.flag &
                        ~((bus_wr && bus_addr == ADDR_W'(A_FLAG)) ? bus_wdata[NUM_LINES-1:0]
                                                                  : '0)) | hit_vec;
            r_d.nmi_flag = (r_q.nmi_flag &
                            ~(bus_wr && bus_addr == ADDR_W'(A_NMIFLAG) && bus_wdata[0])) | nmi_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        pend     = r_q.flag | lvl_vec;
        nmi_pend = r_q.nmi_flag | nmi_lvl;
        irq_o    = |(pend & r_q.mask);
        wake_o   = |(pend & r_q.wake_en);
        nmi_o    = nmi_pend;
        evt_o    = hit_vec & r_q.evt_en;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[0] = busy & rst_pend;
            bus_rdata[1] = busy ? en_req : en_eff;
        end
        if (bus_addr == ADDR_W'(A_STAT))    bus_rdata[0] = busy;
        if (bus_addr == ADDR_W'(A_NMICFG))  bus_rdata[FIELD_W-1:0] = r_q.nmi_cfg;
        if (bus_addr == ADDR_W'(A_EVTEN))   bus_rdata[NUM_LINES-1:0] = r_q.evt_en;
        if (bus_addr == ADDR_W'(A_IRQSET) || bus_addr == ADDR_W'(A_IRQCLR))
            bus_rdata[NUM_LINES-1:0] = r_q.mask;
        if (bus_addr == ADDR_W'(A_WAKEEN))  bus_rdata[NUM_LINES-1:0] = r_q.wake_en;
        if (bus_addr == ADDR_W'(A_FLAG))    bus_rdata[NUM_LINES-1:0] = pend;
        if (bus_addr == ADDR_W'(A_NMIFLAG)) bus_rdata[0] = nmi_pend;
        for (int k = 0; k < CFG_REGS; k++) begin
            if (bus_addr == ADDR_W'(A_CFG0 + 4 * k))
                bus_rdata = r_q.cfg[k*DATA_W +: DATA_W];
        end
    end

    // R13
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_reset |=> (r_q.mask == '0 && r_q.cfg == '0 && r_q.flag == '0 &&
                      r_q.wake_en == '0 && !en_eff));

    // R6
    flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_FLAG) && hit_vec == '0 && !do_reset)
        |=> ((r_q.flag & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_IRQSET) && !do_reset)
        |=> ((r_q.mask & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    // R8
    async_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_vec & r_q.wake_en) != '0) |-> wake_o);

    // R11
    nmi_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.nmi_flag && r_q.mask == '0) |-> nmi_o);

endmodule

// File: tb/eic_wake_ctrl_tb_top.sv
module eic_wake_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_tick = 1'b0;
    logic [15:0] pins_i = '0;
    logic        nmi_pin_i = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o, wake_o;
    logic [15:0] evt_o;

    int checks = 0;
    int fails  = 0;
    int evt_cnt = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    eic_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .det_tick(det_tick), .pins_i(pins_i),
        .nmi_pin_i(nmi_pin_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .nmi_o(nmi_o), .wake_o(wake_o), .evt_o(evt_o)
    );

    always @(posedge clk) if (rst_n) evt_cnt <= evt_cnt + $countones(evt_o);

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{8'h20, 32'h5432_10CD, 8'h20, 32'h5432_10CD},  // R2
        '{8'h24, 32'hA987_6543, 8'h24, 32'hA987_6543},  // R2
        '{8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_000F},  // R11
        '{8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_FFFF},  // R10
        '{8'h18, 32'h0000_1234, 8'h18, 32'h0000_1234},  // R7
        '{8'h10, 32'h0000_00F0, 8'h10, 32'h0000_00F0},  // R3
        '{8'h10, 32'h0000_0003, 8'h10, 32'h0000_00F3},  // R3
        '{8'h14, 32'h0000_0010, 8'h14, 32'h0000_00E3},  // R3
        '{8'h14, 32'h0000_0000, 8'h10, 32'h0000_00E3},  // R3
        '{8'h10, 32'h0000_0000, 8'h14, 32'h0000_00E3}   // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        det_tick = 1'b1;
        repeat (n) @(negedge clk);
        det_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 CTRL", 8'h00, 0);
        rdchk("R1 STAT", 8'h04, 0);
        rdchk("R1 CFG0", 8'h20, 0);
        rdchk("R1 IRQSET", 8'h10, 0);
        rdchk("R1 FLAG", 8'h1C, 0);
        chk("R1 outputs", {29'd0, irq_o, wake_o, nmi_o}, 0);

        // table walk: R2 R3 register semantics
        for (int i = 0; i < 10; i++) begin
            logic [31:0] v;
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v);
            checks++;
            if (v !== VECS[i].exp) begin
                fails++;
                $display("FAIL R2/R3 table entry %0d actual=%h expected=%h", i, v, VECS[i].exp);
            end
        end

        // R13 soft reset
        wr(8'h00, 32'h1);
        rdchk("R13 reset pending", 8'h00, 32'h1);
        rdchk("R12 busy during reset", 8'h04, 32'h1);
        ticks(2);
        rdchk("R12 busy cleared", 8'h04, 0);
        rdchk("R13 reset self-clears", 8'h00, 0);
        rdchk("R13 CFG0 default", 8'h20, 0);
        rdchk("R13 mask default", 8'h10, 0);
        rdchk("R13 EVTEN default", 8'h0C, 0);

        // R12 enable synchronized
        wr(8'h00, 32'h2);
        repeat (3) @(negedge clk);
        rdchk("R12 busy while tick stopped", 8'h04, 32'h1);
        wr(8'h00, 32'h0);
        ticks(1);
        rdchk("R12 busy after one tick", 8'h04, 32'h1);
        ticks(1);
        rdchk("R12 busy after two ticks", 8'h04, 0);
        rdchk("R12 write while busy ignored", 8'h00, 32'h2);

        // R4 edges
        wr(8'h20, 32'h0000_0321);
        wr(8'h10, 32'h1);
        wr(8'h0C, 32'h4);
        base = evt_cnt;
        pins_i[0] = 1'b1; ticks(6);
        rdchk("R4 rising flag", 8'h1C, 32'h1);
        chk("R6 irq on enabled flag", {31'd0, irq_o}, 1);
        chk("R10 no event when disabled", evt_cnt - base, 0);
        wr(8'h1C, 32'h1);
        rdchk("R6 flag w1c", 8'h1C, 0);
        chk("R6 irq cleared", {31'd0, irq_o}, 0);
        pins_i[0] = 1'b0; ticks(6);
        rdchk("R4 rising ignores fall", 8'h1C, 0);
        pins_i[1] = 1'b1; ticks(6);
        rdchk("R4 falling ignores rise", 8'h1C, 0);
        pins_i[1] = 1'b0; ticks(6);
        rdchk("R4 falling flag", 8'h1C, 32'h2);
        chk("R6 irq masked line", {31'd0, irq_o}, 0);
        wr(8'h1C, 32'h2);
        base = evt_cnt;
        pins_i[2] = 1'b1; ticks(6);
        pins_i[2] = 1'b0; ticks(6);
        rdchk("R4 both edges flag", 8'h1C, 32'h4);
        chk("R10 two event pulses", evt_cnt - base, 2);
        wr(8'h1C, 32'h4);
        pins_i[3] = 1'b1; ticks(6);
        pins_i[3] = 1'b0; ticks(6);
        rdchk("R4 sense none", 8'h1C, 0);

        // R5 filter
        wr(8'h20, 32'h0009_0000);
        @(negedge clk); det_tick = 1'b1;
        @(negedge clk); pins_i[4] = 1'b1;
        @(negedge clk); pins_i[4] = 1'b0;
        ticks(6);
        rdchk("R5 glitch rejected", 8'h1C, 0);
        pins_i[4] = 1'b1; ticks(6);
        rdchk("R5 steady edge passes", 8'h1C, 32'h10);

        // R7 wake independent of mask
        wr(8'h18, 32'h10);
        chk("R7 wake high", {31'd0, wake_o}, 1);
        chk("R7 irq stays low", {31'd0, irq_o}, 0);
        wr(8'h1C, 32'h10);
        chk("R7 wake low after clear", {31'd0, wake_o}, 0);
        pins_i[4] = 1'b0; ticks(6);

        // R8 clockless level path
        wr(8'h24, 32'h0000_0004);
        wr(8'h18, 32'h100);
        wr(8'h10, 32'h100);
        @(negedge clk); pins_i[8] = 1'b1;
        #1 chk("R8 wake without tick", {30'd0, wake_o, irq_o}, 2'b11);
        rdchk("R8 pending without tick", 8'h1C, 32'h100);
        @(negedge clk); pins_i[8] = 1'b0;
        #1 chk("R8 wake follows pin", {30'd0, wake_o, irq_o}, 0);
        wr(8'h24, 32'h0000_0050);
        rdchk("R8 low level pending", 8'h1C, 32'h200);
        wr(8'h24, 32'h0);

        // R9 filtered level
        wr(8'h24, 32'h0000_0C00);
        pins_i[10] = 1'b1;
        repeat (5) @(negedge clk);
        rdchk("R9 no flag without tick", 8'h1C, 0);
        ticks(6);
        rdchk("R9 flag on ticks", 8'h1C, 32'h400);
        wr(8'h1C, 32'h400);
        rdchk("R9 cleared", 8'h1C, 0);
        ticks(2);
        rdchk("R9 re-flags while level held", 8'h1C, 32'h400);
        pins_i[10] = 1'b0; ticks(6);
        wr(8'h1C, 32'h400);

        // R11 NMI
        wr(8'h14, 32'hFFFF);
        wr(8'h08, 32'h1);
        nmi_pin_i = 1'b1; ticks(6);
        chk("R11 nmi asserted", {31'd0, nmi_o}, 1);
        rdchk("R11 nmi flag", 8'h28, 32'h1);
        chk("R11 irq unaffected", {31'd0, irq_o}, 0);
        wr(8'h28, 32'h1);
        rdchk("R11 nmi flag w1c", 8'h28, 0);
        chk("R11 nmi released", {31'd0, nmi_o}, 0);
        nmi_pin_i = 1'b0; ticks(6);

        // R13 reset from enabled state
        wr(8'h00, 32'h1);
        ticks(3);
        rdchk("R13 disabled after reset", 8'h00, 0);
        rdchk("R13 CFG1 default", 8'h24, 0);
        rdchk("R13 WAKEEN default", 8'h18, 0);
        chk("R13 outputs low", {30'd0, irq_o, wake_o}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule